// File: doc/BRIEF.md
# Banked GPIO Register Port

This block is a memory-mapped general-purpose I/O port. Its pins are grouped into banks of 32. Each bank owns one register set inside a single register window. A register set holds a direction word, a set-strobe word, a clear-strobe word and an input word. Software moves output levels only through the set and clear strobes, so one bus write changes only the pins whose mask bits are one. The input word always returns the pin level after a two-stage synchronizer, whether the pin is driven by this port or by something outside it.

The bus is a single-cycle request interface. A request is accepted on every clock edge where `bus_sel` is high. A write takes effect at that edge. A read is answered in the next cycle through `bus_rvalid` and `bus_rdata`. The read response is sequenced by a two-state machine. `BUS_IDLE` means no read response is pending. `BUS_RESP` means read data is on the bus this cycle. Transitions: IDLE→RESP and RESP→RESP on an accepted read; RESP→IDLE and IDLE→IDLE otherwise.

The register-set bases, the fixed 32-pin bank width and the per-set register order are listed in R7. Pin and output-enable drive go straight out to the pad ring. Pad muxing and interrupt generation are handled elsewhere.

Top module: `gpio_bank_regs`

## Requirements
- R1: While `rst_n` is low, and right after it rises, every pin is an input (`pin_oe` all zero), every output latch bit is 0 (`pin_out` all zero), and `bus_rvalid` is 0.
- R2: A write to a bank's direction word replaces that bank's direction bits. A direction bit of 1 makes the pin an input (`pin_oe` bit 0). A bit of 0 makes it an output (`pin_oe` bit 1). The direction word reads back as written, and `pin_oe` changes only at the edge of a direction write.
- R3: A write to the set-strobe word drives high exactly the pins whose mask bit is 1; pins with a 0 mask bit keep their level. Output levels change only at the edge of a set or clear write.
- R4: A write to the clear-strobe word drives low exactly the pins whose mask bit is 1; pins with a 0 mask bit keep their level.
- R5: Reading the set-strobe word returns the bank's current output latch. Reading the clear-strobe word returns 0.
- R6: Reading the input word returns the pin level, whatever the direction. A read accepted at edge k returns the `pin_in` value sampled at edge k-2. A pin change just before edge k is therefore first seen by a read accepted at edge k+2.
- R7: Bank b's register set starts at byte address 0x10 + 0x28·b, for b in 0..NUM_BANKS-1 (at most 5). Within a set: direction at +0x0, set-strobe at +0x4, clear-strobe at +0x8, input at +0xC. Pin n belongs to bank n/32 and uses bit n mod 32 of each word and of the pin vectors.
- R8: An address outside every register set is unmapped. This includes the gaps between sets, offsets past the last bank, and any address with bit 0 or bit 1 set. Reads of an unmapped address return 0. Writes to one change no direction bit and no output level.
- R9: A read accepted at edge t raises `bus_rvalid` for exactly the cycle after t, with the read word on `bus_rdata`. Back-to-back reads give back-to-back responses. Whenever `bus_rvalid` is low, `bus_rdata` is 0.
- R10: `pin_out` always shows the output latch, even for input pins. If a level is preset with a set or clear write before the direction write, the pin starts driving that level in the same cycle its `pin_oe` rises.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Port clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_sel | input | 1 | Request valid this cycle |
| bus_wr | input | 1 | 1 = write request, 0 = read request |
| bus_addr | input | ADDR_W | Byte address within the register window |
| bus_wdata | input | 32 | Write data or strobe mask |
| bus_rdata | output | 32 | Read data, valid with `bus_rvalid`, otherwise 0 |
| bus_rvalid | output | 1 | Read response cycle |
| pin_in | input | NUM_BANKS·32 | Pin levels from the pads (asynchronous) |
| pin_out | output | NUM_BANKS·32 | Output latch levels to the pads |
| pin_oe | output | NUM_BANKS·32 | Output enable per pin, 1 = drive |

## Verification
The assertions assume one request per cycle and treat `bus_wr` and `bus_addr` as meaningful only while `bus_sel` is high. They also assume `bus_wdata` holds its value through the accepting edge. They make no assumption about `pin_in`, which may change in any cycle. The stimulus changes every bus input and every pin only on the falling clock edge, so each request is stable across the edge that accepts it. Addresses are drawn both from the mapped register offsets of every bank and from the gaps, the area past the last bank and misaligned bytes.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

    localparam int unsigned BANK_PINS   = 32;
    localparam int unsigned BANK_BASE0  = 'h10;
    localparam int unsigned BANK_STRIDE = 'h28;
    localparam int unsigned SET_SPAN    = 'h10;
    localparam int unsigned MAX_BANKS   = 5;

    typedef enum logic [1:0] {
        REG_DIR = 2'd0,
        REG_SET = 2'd1,
        REG_CLR = 2'd2,
        REG_IN  = 2'd3
    } reg_kind_e;

    typedef enum logic {
        BUS_IDLE = 1'b0,
        BUS_RESP = 1'b1
    } bus_state_e;

endpackage

// File: rtl/gpio_addr_decode.sv
module gpio_addr_decode
    import gpio_bank_pkg::*;
#(
    parameter int unsigned NUM_BANKS = 5,
    parameter int unsigned ADDR_W    = 8
) (
    input  logic [ADDR_W-1:0]    addr,
    output logic [NUM_BANKS-1:0] bank_hit,
    output reg_kind_e            kind
);

    logic [1:0] sub_sel [NUM_BANKS];

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_win
        localparam int unsigned BASE = BANK_BASE0 + b * BANK_STRIDE;
        localparam logic [ADDR_W-1:0] BASE_A = ADDR_W'(BASE);
        localparam logic [ADDR_W-1:0] LAST_A = ADDR_W'(BASE + SET_SPAN - 1);
        logic [ADDR_W-1:0] rel;

        assign rel        = addr - BASE_A;
        assign sub_sel[b] = rel[3:2];
        assign bank_hit[b] = (addr >= BASE_A) && (addr <= LAST_A)
                             && (addr[1:0] == 2'b00);
    end

    always_comb begin
        logic [1:0] k;
        k = 2'b00;
        for (int b = 0; b < NUM_BANKS; b++) begin
            if (bank_hit[b]) k = k | sub_sel[b];
        end
        kind = reg_kind_e'(k);
    end

endmodule

// File: rtl/gpio_bank_store.sv
module gpio_bank_store
    import gpio_bank_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_dir,
    input  logic                 wr_set,
    input  logic                 wr_clr,
    input  logic [BANK_PINS-1:0] wdata,
    output logic [BANK_PINS-1:0] dir_q,
    output logic [BANK_PINS-1:0] out_q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dir_q <= '1;
        end else if (wr_dir) begin
            dir_q <= wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q <= '0;
        end else if (wr_set) begin
            out_q <= out_q | wdata;
        end else if (wr_clr) begin
            out_q <= out_q & ~wdata;
        end
    end

endmodule

// File: rtl/gpio_sync2.sv
module gpio_sync2 #(
    parameter int unsigned WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);

    logic [WIDTH-1:0] stage1_q;
    logic [WIDTH-1:0] stage2_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage1_q <= '0;
            stage2_q <= '0;
        end else begin
            stage1_q <= async_in;
            stage2_q <= stage1_q;
        end
    end

    assign sync_out = stage2_q;

endmodule

// File: rtl/gpio_bank_regs.sv
module gpio_bank_regs
    import gpio_bank_pkg::*;
#(
    parameter int unsigned NUM_BANKS = 5,
    parameter int unsigned ADDR_W    = 8
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             bus_sel,
    input  logic                             bus_wr,
    input  logic [ADDR_W-1:0]                bus_addr,
    input  logic [BANK_PINS-1:0]             bus_wdata,
    output logic [BANK_PINS-1:0]             bus_rdata,
    output logic                             bus_rvalid,
    input  logic [NUM_BANKS*BANK_PINS-1:0]   pin_in,
    output logic [NUM_BANKS*BANK_PINS-1:0]   pin_out,
    output logic [NUM_BANKS*BANK_PINS-1:0]   pin_oe
);

    localparam int unsigned NPINS = NUM_BANKS * BANK_PINS;

    logic [NUM_BANKS-1:0] bank_hit;
    reg_kind_e            kind;
    logic                 acc_wr;
    logic                 acc_rd;
    logic [NPINS-1:0]     dir_all;
    logic [NPINS-1:0]     out_all;
    logic [NPINS-1:0]     in_sync;
    logic [BANK_PINS-1:0] rd_word;
    logic [BANK_PINS-1:0] rdata_q;
    bus_state_e           state_q;
    bus_state_e           state_d;

    assign acc_wr = bus_sel && bus_wr;
    assign acc_rd = bus_sel && !bus_wr;

    gpio_addr_decode #(
        .NUM_BANKS (NUM_BANKS),
        .ADDR_W    (ADDR_W)
    ) u_dec (
        .addr     (bus_addr),
        .bank_hit (bank_hit),
        .kind     (kind)
    );

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        logic wr_here;
        assign wr_here = acc_wr && bank_hit[b];

        gpio_bank_store u_store (
            .clk    (clk),
            .rst_n  (rst_n),
            .wr_dir (wr_here && (kind == REG_DIR)),
            .wr_set (wr_here && (kind == REG_SET)),
            .wr_clr (wr_here && (kind == REG_CLR)),
            .wdata  (bus_wdata),
            .dir_q  (dir_all[b*BANK_PINS +: BANK_PINS]),
            .out_q  (out_all[b*BANK_PINS +: BANK_PINS])
        );
    end

    gpio_sync2 #(
        .WIDTH (NPINS)
    ) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pin_in),
        .sync_out (in_sync)
    );

    // Read word selection: one-hot bank hit, then register kind.
    always_comb begin
        rd_word = '0;
        for (int b = 0; b < NUM_BANKS; b++) begin
            if (bank_hit[b]) begin
                unique case (kind)
                    REG_DIR: rd_word = dir_all[b*BANK_PINS +: BANK_PINS];
                    REG_SET: rd_word = out_all[b*BANK_PINS +: BANK_PINS];
                    REG_CLR: rd_word = '0;
                    REG_IN:  rd_word = in_sync[b*BANK_PINS +: BANK_PINS];
                endcase
            end
        end
    end

    // Response state register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= BUS_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            BUS_IDLE: state_d = acc_rd ? BUS_RESP : BUS_IDLE;
            BUS_RESP: state_d = acc_rd ? BUS_RESP : BUS_IDLE;
        endcase
    end

    // Response data register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else begin
            rdata_q <= acc_rd ? rd_word : '0;
        end
    end

    assign bus_rvalid = (state_q == BUS_RESP);
    assign bus_rdata  = rdata_q;
    assign pin_out    = out_all;
    assign pin_oe     = ~dir_all;

endmodule

// File: rtl/gpio_bank_regs_chk.sv
module gpio_bank_regs_chk
    import gpio_bank_pkg::*;
#(
    parameter int unsigned NUM_BANKS = 5,
    parameter int unsigned ADDR_W    = 8
) (
    input logic                           clk,
    input logic                           rst_n,
    input logic                           bus_sel,
    input logic                           bus_wr,
    input logic [ADDR_W-1:0]              bus_addr,
    input logic [BANK_PINS-1:0]           bus_wdata,
    input logic [BANK_PINS-1:0]           bus_rdata,
    input logic                           bus_rvalid,
    input logic [NUM_BANKS*BANK_PINS-1:0] pin_out,
    input logic [NUM_BANKS*BANK_PINS-1:0] pin_oe
);

    function automatic logic in_window(logic [ADDR_W-1:0] a);
        for (int b = 0; b < NUM_BANKS; b++) begin
            int base;
            base = BANK_BASE0 + b * BANK_STRIDE;
            if (int'(a) >= base && int'(a) < base + SET_SPAN && a[1:0] == 2'b00)
                return 1'b1;
        end
        return 1'b0;
    endfunction

    // R1
    reset_state_chk: assert property (@(posedge clk)
        !rst_n |=> (pin_oe == '0 && pin_out == '0 && !bus_rvalid));

    // R9
    rvalid_follows_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && !bus_wr) |=> bus_rvalid);

    // R9
    rvalid_only_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_sel && !bus_wr) |=> !bus_rvalid);

    // R9
    rdata_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rvalid |-> bus_rdata == '0);

    // R2
    oe_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_sel && bus_wr) |=> $stable(pin_oe));

    // R3
    out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_sel && bus_wr) |=> $stable(pin_out));

    // R8
    unmapped_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_wr && !in_window(bus_addr)) |=> ($stable(pin_out) && $stable(pin_oe)));

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank_chk
        localparam logic [ADDR_W-1:0] SET_A = ADDR_W'(BANK_BASE0 + b * BANK_STRIDE + 4);
        localparam logic [ADDR_W-1:0] CLR_A = ADDR_W'(BANK_BASE0 + b * BANK_STRIDE + 8);

        // R3
        set_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (bus_sel && bus_wr && bus_addr == SET_A)
            |=> ((pin_out[b*BANK_PINS +: BANK_PINS] & $past(bus_wdata)) == $past(bus_wdata)));

        // R4
        clr_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (bus_sel && bus_wr && bus_addr == CLR_A)
            |=> ((pin_out[b*BANK_PINS +: BANK_PINS] & $past(bus_wdata)) == '0));
    end

endmodule

bind gpio_bank_regs gpio_bank_regs_chk #(
    .NUM_BANKS (NUM_BANKS),
    .ADDR_W    (ADDR_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_sel    (bus_sel),
    .bus_wr     (bus_wr),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .bus_rvalid (bus_rvalid),
    .pin_out    (pin_out),
    .pin_oe     (pin_oe)
);

// File: tb/gpio_bank_regs_test.sv
module gpio_bank_regs_test;

    localparam int NB = 5;
    localparam int AW = 8;
    localparam int NP = NB * 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_sel = 1'b0;
    logic          bus_wr = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic          bus_rvalid;
    logic [NP-1:0] pin_in = '0;
    logic [NP-1:0] pin_out;
    logic [NP-1:0] pin_oe;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    gpio_bank_regs #(.NUM_BANKS(NB), .ADDR_W(AW)) uut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_rvalid(bus_rvalid), .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe)
    );

    // ---------------- behavioural reference ----------------
    logic [31:0]   m_dir [NB];
    logic [31:0]   m_out [NB];
    logic [NP-1:0] hist [$];
    logic [31:0]   e_rdata = '0;
    logic          e_rvalid = 1'b0;

    function automatic int addr_of(int bank, int regno);
        return 16 + 40 * bank + 4 * regno;
    endfunction

    function automatic bit decode(int a, output int bank, output int regno);
        bank = 0; regno = 0;
        for (int b = 0; b < NB; b++) begin
            if (a >= 16 + 40 * b && a < 32 + 40 * b && (a % 4) == 0) begin
                bank = b; regno = (a - 16 - 40 * b) / 4;
                return 1;
            end
        end
        return 0;
    endfunction

    always @(posedge clk) begin
        int bk, rg;
        logic [NP-1:0] sv;
        if (!rst_n) begin
            for (int b = 0; b < NB; b++) begin m_dir[b] = '1; m_out[b] = '0; end
            hist.delete();
            e_rdata = '0; e_rvalid = 1'b0;
        end else begin
            sv = (hist.size() < 2) ? '0 : hist[0];
            e_rvalid = bus_sel && !bus_wr;
            e_rdata = '0;
            if (decode(int'(bus_addr), bk, rg) && bus_sel) begin
                if (!bus_wr) begin
                    case (rg)
                        0: e_rdata = m_dir[bk];
                        1: e_rdata = m_out[bk];
                        2: e_rdata = '0;
                        default: e_rdata = sv[bk*32 +: 32];
                    endcase
                end else begin
                    case (rg)
                        0: m_dir[bk] = bus_wdata;
                        1: m_out[bk] = m_out[bk] | bus_wdata;
                        2: m_out[bk] = m_out[bk] & ~bus_wdata;
                        default: ;
                    endcase
                end
            end
            hist.push_back(pin_in);
            if (hist.size() > 2) void'(hist.pop_front());
        end
    end

    task automatic chk(string tag, logic [NP-1:0] act, logic [NP-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Per-cycle comparison against the reference.
    always @(negedge clk) begin
        logic [NP-1:0] eo, ed;
        if (rst_n && !finished) begin
            for (int b = 0; b < NB; b++) begin
                eo[b*32 +: 32] = m_out[b];
                ed[b*32 +: 32] = ~m_dir[b];
            end
            chk("R3/R4 model pin_out", pin_out, eo);
            chk("R2 model pin_oe", pin_oe, ed);
            chk("R9 model rvalid", NP'(bus_rvalid), NP'(e_rvalid));
            chk("R5/R6/R8 model rdata", NP'(bus_rdata), NP'(e_rdata));
        end
    end

    // ---------------- stimulus tasks ----------------
    task automatic wr(int a, logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = AW'(a); bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(int a, output logic [31:0] d);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = AW'(a);
        @(negedge clk);
        bus_sel = 1'b0;
        d = bus_rdata;
    endtask

    task automatic rd_chk(string tag, int a, logic [31:0] exp);
        logic [31:0] d;
        @(negedge clk);
        rd(a, d);
        chk(tag, NP'(d), NP'(exp));
    endtask

    initial begin
        logic [31:0] d0, d1, d2;
        repeat (4) @(negedge clk);
        // R1 reset state
        chk("R1 pin_oe in reset", pin_oe, '0);
        chk("R1 pin_out in reset", pin_out, '0);
        chk("R1 rvalid in reset", NP'(bus_rvalid), '0);
        rst_n = 1'b1;
        rd_chk("R1 direction resets to inputs", addr_of(0, 0), 32'hFFFF_FFFF);

        // R2 direction
        wr(addr_of(1, 0), 32'h0000_FF00);
        chk("R2 oe bank1", NP'(pin_oe[63:32]), NP'(32'hFFFF_00FF));
        rd_chk("R2 direction readback", addr_of(1, 0), 32'h0000_FF00);

        // R3 set, R4 clear, R5 readback
        wr(addr_of(0, 1), 32'h0000_0005);
        wr(addr_of(0, 1), 32'h0000_0100);
        rd_chk("R3 set accumulates", addr_of(0, 1), 32'h0000_0105);
        wr(addr_of(0, 2), 32'h0000_0004);
        chk("R4 clear one pin", NP'(pin_out[31:0]), NP'(32'h0000_0101));
        rd_chk("R5 clear word reads zero", addr_of(0, 2), 32'h0);
        rd_chk("R5 set word returns latch", addr_of(0, 1), 32'h0000_0101);

        // R7 last bank, top pin
        wr(addr_of(4, 1), 32'h8000_0000);
        chk("R7 pin 159 via bank4", NP'(pin_out[159]), NP'(1'b1));
        chk("R7 bank3 untouched", NP'(pin_out[127:96]), '0);

        // R8 unmapped accesses
        wr(8'h20, 32'hFFFF_FFFF);
        wr(8'hC0, 32'hFFFF_FFFF);
        wr(8'h14 | 8'h2, 32'hFFFF_FFFF);
        wr(8'h08, 32'h0);
        chk("R8 pin_out after unmapped writes", NP'(pin_out[31:0]), NP'(32'h0000_0101));
        chk("R8 pin_oe after unmapped writes", NP'(pin_oe[31:0]), '0);
        rd_chk("R8 gap read", 8'h30, 32'h0);
        rd_chk("R8 past last bank read", 8'hC4, 32'h0);
        rd_chk("R8 misaligned read", 8'h11, 32'h0);

        // R10 preset level then enable drive
        wr(addr_of(2, 1), 32'h0000_0001);
        chk("R10 level visible while input", NP'(pin_out[64]), NP'(1'b1));
        chk("R10 not yet driving", NP'(pin_oe[64]), '0);
        wr(addr_of(2, 0), 32'hFFFF_FFFE);
        chk("R10 drives preset level", NP'({pin_oe[64], pin_out[64]}), NP'(2'b11));

        // R6 synchronizer latency, bank2 partly an output
        repeat (3) @(negedge clk);
        pin_in[95:64] = 32'hA5A5_0001;
        rd(addr_of(2, 3), d0);
        rd(addr_of(2, 3), d1);
        rd(addr_of(2, 3), d2);
        chk("R6 read at change edge old", NP'(d0), '0);
        chk("R6 read one edge later old", NP'(d1), '0);
        chk("R6 read two edges later new", NP'(d2), NP'(32'hA5A5_0001));
        // R9 back-to-back responses were produced above; check a lone read
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = AW'(addr_of(1, 0));
        @(negedge clk);
        bus_sel = 1'b0;
        chk("R9 rvalid after read", NP'(bus_rvalid), NP'(1'b1));
        chk("R9 rdata with rvalid", NP'(bus_rdata), NP'(32'h0000_FF00));
        @(negedge clk);
        chk("R9 rvalid single cycle", NP'(bus_rvalid), '0);
        chk("R9 rdata zero when idle", NP'(bus_rdata), '0);

        // Mixed traffic checked by the reference on every clock
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk);
            if ($urandom_range(0, 4) == 0) pin_in = {$urandom(), $urandom(), $urandom(), $urandom(), $urandom()};
            bus_sel = ($urandom_range(0, 3) != 0);
            bus_wr = $urandom_range(0, 1) == 1;
            if ($urandom_range(0, 5) == 0)
                bus_addr = AW'($urandom_range(0, 255));
            else
                bus_addr = AW'(addr_of($urandom_range(0, NB - 1), $urandom_range(0, 3)));
            bus_wdata = $urandom();
        end
        @(negedge clk);
        bus_sel = 1'b0;
        repeat (3) @(negedge clk);
        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_chk++; n_fail++;
            $display("FAIL R9 watchdog actual=hung expected=done");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule